// File: doc/BRIEF.md
# Central-Stage Link Arbiter with Open Grants

This block arbitrates the output links of one central switching module in a three-stage switch fabric. Every input-module link may present one request per time slot, naming the single output link it wants. Each output link runs a round-robin arbiter over the inputs that name it and returns a normal grant to one of them.

Once that pass is complete, some output links may have no requester while some inputs have lost their contest. A second pass hands each such idle link to one losing input as an open grant. The open grant carries the index of the idle link. That index is also the output module the link reaches, so the input module may send any cell bound for that output module. Both passes finish in one cycle, and the responses are presented from registers in the next cycle. The input module signals back when it actually used an open grant. Only then does the open-pass pointer of that link move.

Top module: `cm_open_grant_arb`

## Requirements
- R1: While reset is held, and in the first cycle after it, `grant`, `open_grant` and `grant_om` are all zero. Every round-robin pointer starts at input 0.
- R2: If at least one input requests output link j in a cycle, then exactly one of those inputs shows `grant` in the next cycle, and its `grant_om` field equals j.
- R3: A link's normal arbiter searches upward, with wraparound, from its grant pointer. After a normal grant the pointer moves to one past the winning input.
- R4: A link that receives no request leaves its grant pointer unchanged.
- R5: A link with no requester in a cycle gives an open grant to one requesting input that received no normal grant, if one remains. The `grant_om` of that input equals the idle link's index.
- R6: In any cycle an input shows at most one response, either a grant or an open grant. Each output link index appears in at most one response.
- R7: In the open pass, idle links are served in ascending index order. Each link searches upward from its own open pointer among the ungranted requesters that no lower link has already taken.
- R8: A link's open pointer moves to one past input i only at a clock edge where input i shows `open_grant` for that link and drives `og_accept[i]` high. Otherwise the open pointer keeps its value.
- R9: An input that did not request in a cycle shows no response in the next cycle. Responses always appear one cycle after the request.
- R10: `grant_om` of an input is zero whenever that input shows no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_IN | Per input: a request is present this slot |
| req_dest | input | NUM_IN*OW | Per input: requested output link, field i at bits i*OW |
| og_accept | input | NUM_IN | Per input: the open grant shown this cycle is being used |
| grant | output | NUM_IN | Per input: normal grant for the requested link |
| open_grant | output | NUM_IN | Per input: open grant for an idle link |
| grant_om | output | NUM_IN*OW | Per input: output link / output module index of the response |

## Verification
The assertions assume that every valid `req_dest` field names an existing link. With the default four links, every 2-bit code is legal, so the stimulus cannot leave that range. They also assume that `og_accept` matters only while the matching `open_grant` is shown. The directed scenarios raise accept only in the cycle where the open grant it answers is on the outputs. The link-level properties compare a response with the requests one cycle earlier. For that reason each scenario holds its requests for exactly one slot, and the checks sample one register stage later.

// File: rtl/cmog_pkg.sv
package cmog_pkg;

    typedef enum logic [1:0] {
        RK_NONE  = 2'd0,
        RK_GRANT = 2'd1,
        RK_OPEN  = 2'd2
    } resp_kind_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int next_slot(input int cur, input int n);
        return (cur + 1) % n;
    endfunction

endpackage

// File: rtl/cmog_rr_pick.sv
module cmog_rr_pick #(
    parameter int N = 4,
    localparam int IW = cmog_pkg::idx_width(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            if (!found && req[(int'(start) + k) % N]) begin
                found = 1'b1;
                idx   = IW'((int'(start) + k) % N);
            end
        end
    end
endmodule

// File: rtl/cmog_link.sv
module cmog_link #(
    parameter int NUM_IN = 4,
    localparam int IW = cmog_pkg::idx_width(NUM_IN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] tgt_mask,
    input  logic [NUM_IN-1:0] og_pool,
    input  logic              og_adv,
    input  logic [IW-1:0]     og_adv_who,
    output logic              grant_hit,
    output logic [IW-1:0]     grant_who,
    output logic              og_hit,
    output logic [IW-1:0]     og_who
);
    logic [IW-1:0]     gp_q;
    logic [IW-1:0]     op_q;
    logic [NUM_IN-1:0] og_req;

    cmog_rr_pick #(.N(NUM_IN)) u_gpick (
        .req   (tgt_mask),
        .start (gp_q),
        .found (grant_hit),
        .idx   (grant_who)
    );

    // open pass only on a link that no input asked for
    assign og_req = grant_hit ? '0 : og_pool;

    cmog_rr_pick #(.N(NUM_IN)) u_opick (
        .req   (og_req),
        .start (op_q),
        .found (og_hit),
        .idx   (og_who)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gp_q <= '0;
            op_q <= '0;
        end else begin
            if (grant_hit)
                gp_q <= IW'(cmog_pkg::next_slot(int'(grant_who), NUM_IN));
            if (og_adv)
                op_q <= IW'(cmog_pkg::next_slot(int'(og_adv_who), NUM_IN));
        end
    end
endmodule

// File: rtl/cm_open_grant_arb.sv
module cm_open_grant_arb #(
    parameter int NUM_IN  = 4,
    parameter int NUM_OUT = 4,
    localparam int IW = cmog_pkg::idx_width(NUM_IN),
    localparam int OW = cmog_pkg::idx_width(NUM_OUT)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_IN-1:0]    req_valid,
    input  logic [NUM_IN*OW-1:0] req_dest,
    input  logic [NUM_IN-1:0]    og_accept,
    output logic [NUM_IN-1:0]    grant,
    output logic [NUM_IN-1:0]    open_grant,
    output logic [NUM_IN*OW-1:0] grant_om
);
    import cmog_pkg::*;

    logic [NUM_IN-1:0] tgt_mask [NUM_OUT];
    logic [NUM_IN-1:0] pool     [NUM_OUT+1];
    logic [NUM_OUT-1:0] grant_hit, og_hit, og_adv;
    logic [IW-1:0]     grant_who  [NUM_OUT];
    logic [IW-1:0]     og_who     [NUM_OUT];
    logic [IW-1:0]     og_adv_who [NUM_OUT];
    logic [NUM_IN-1:0] granted;

    resp_kind_e    kind_n [NUM_IN];
    resp_kind_e    kind_q [NUM_IN];
    logic [OW-1:0] om_n   [NUM_IN];
    logic [OW-1:0] om_q   [NUM_IN];

    always_comb begin
        granted = '0;
        for (int j = 0; j < NUM_OUT; j++)
            if (grant_hit[j]) granted[grant_who[j]] = 1'b1;
    end

    assign pool[0] = req_valid & ~granted;

    for (genvar j = 0; j < NUM_OUT; j++) begin : g_link
        always_comb begin
            for (int i = 0; i < NUM_IN; i++)
                tgt_mask[j][i] = req_valid[i] && (req_dest[i*OW +: OW] == OW'(j));
        end

        always_comb begin
            og_adv[j]     = 1'b0;
            og_adv_who[j] = '0;
            for (int i = 0; i < NUM_IN; i++) begin
                if (kind_q[i] == RK_OPEN && og_accept[i] && om_q[i] == OW'(j)) begin
                    og_adv[j]     = 1'b1;
                    og_adv_who[j] = IW'(i);
                end
            end
        end

        cmog_link #(.NUM_IN(NUM_IN)) u_link (
            .clk        (clk),
            .rst        (rst),
            .tgt_mask   (tgt_mask[j]),
            .og_pool    (pool[j]),
            .og_adv     (og_adv[j]),
            .og_adv_who (og_adv_who[j]),
            .grant_hit  (grant_hit[j]),
            .grant_who  (grant_who[j]),
            .og_hit     (og_hit[j]),
            .og_who     (og_who[j])
        );

        // lower links claim open candidates first
        assign pool[j+1] = pool[j] & ~(og_hit[j] ? (NUM_IN'(1) << og_who[j]) : '0);
    end

    always_comb begin
        for (int i = 0; i < NUM_IN; i++) begin
            kind_n[i] = RK_NONE;
            om_n[i]   = '0;
        end
        for (int j = 0; j < NUM_OUT; j++) begin
            if (grant_hit[j]) begin
                kind_n[grant_who[j]] = RK_GRANT;
                om_n[grant_who[j]]   = OW'(j);
            end
            if (og_hit[j]) begin
                kind_n[og_who[j]] = RK_OPEN;
                om_n[og_who[j]]   = OW'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_IN; i++) begin
            if (rst) begin
                kind_q[i] <= RK_NONE;
                om_q[i]   <= '0;
            end else begin
                kind_q[i] <= kind_n[i];
                om_q[i]   <= om_n[i];
            end
        end
    end

    for (genvar i = 0; i < NUM_IN; i++) begin : g_out
        assign grant[i]            = (kind_q[i] == RK_GRANT);
        assign open_grant[i]       = (kind_q[i] == RK_OPEN);
        assign grant_om[i*OW +: OW] = om_q[i];
    end
endmodule

// File: rtl/cmog_chk.sv
module cmog_chk #(
    parameter int NUM_IN  = 4,
    parameter int NUM_OUT = 4,
    localparam int OW = cmog_pkg::idx_width(NUM_OUT)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_IN-1:0]    req_valid,
    input logic [NUM_IN*OW-1:0] req_dest,
    input logic [NUM_IN-1:0]    grant,
    input logic [NUM_IN-1:0]    open_grant,
    input logic [NUM_IN*OW-1:0] grant_om
);
    logic [NUM_OUT-1:0] want;
    logic [NUM_IN-1:0]  served [NUM_OUT];

    for (genvar j = 0; j < NUM_OUT; j++) begin : g_lnk
        always_comb begin
            want[j] = 1'b0;
            for (int i = 0; i < NUM_IN; i++) begin
                if (req_valid[i] && req_dest[i*OW +: OW] == OW'(j)) want[j] = 1'b1;
                served[j][i] = (grant[i] || open_grant[i]) && grant_om[i*OW +: OW] == OW'(j);
            end
        end

        p_link_served_r2: assert property (@(posedge clk) disable iff (rst)
            want[j] |=> (|(served[j] & grant)));

        p_link_once_r6: assert property (@(posedge clk) disable iff (rst)
            $countones(served[j]) <= 1);
    end

    for (genvar i = 0; i < NUM_IN; i++) begin : g_inp
        p_single_resp_r6: assert property (@(posedge clk) disable iff (rst)
            !(grant[i] && open_grant[i]));

        p_grant_dest_r2: assert property (@(posedge clk) disable iff (rst)
            grant[i] |-> ($past(req_valid[i]) &&
                          grant_om[i*OW +: OW] == $past(req_dest[i*OW +: OW])));

        p_open_idle_r5: assert property (@(posedge clk) disable iff (rst)
            open_grant[i] |-> (($past(want) & (NUM_OUT'(1) << grant_om[i*OW +: OW])) == '0));

        p_no_req_no_resp_r9: assert property (@(posedge clk) disable iff (rst)
            (grant[i] || open_grant[i]) |-> $past(req_valid[i]));

        p_om_zero_r10: assert property (@(posedge clk) disable iff (rst)
            !(grant[i] || open_grant[i]) |-> grant_om[i*OW +: OW] == '0);
    end
endmodule

bind cm_open_grant_arb cmog_chk #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_dest   (req_dest),
    .grant      (grant),
    .open_grant (open_grant),
    .grant_om   (grant_om)
);

// File: tb/cm_open_grant_arb_test.sv
module cm_open_grant_arb_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] req_valid = '0;
    logic [7:0] req_dest  = '0;
    logic [3:0] og_accept = '0;
    logic [3:0] grant, open_grant;
    logic [7:0] grant_om;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    cm_open_grant_arb #(.NUM_IN(4), .NUM_OUT(4)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_dest(req_dest),
        .og_accept(og_accept), .grant(grant), .open_grant(open_grant),
        .grant_om(grant_om)
    );

    task automatic check4(string tag, string what, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic check8(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // present one slot of requests, then sample the registered response
    task automatic slot(string tag, logic [3:0] v, logic [7:0] d, logic [3:0] acc,
                        logic [3:0] eg, logic [3:0] eo, logic [7:0] eom);
        @(negedge clk);
        req_valid = v;
        req_dest  = d;
        og_accept = acc;
        @(posedge clk);
        #1;
        check4(tag, "grant", grant, eg);
        check4(tag, "open_grant", open_grant, eo);
        check8(tag, "grant_om", grant_om, eom);
        check4("R6", "both responses", grant & open_grant, 4'b0000);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check4("R1", "grant in reset", grant, 4'b0000);
        check4("R1", "open in reset", open_grant, 4'b0000);
        check8("R1", "om in reset", grant_om, 8'h00);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // R2 R3 R5 R7: three inputs contend for link 1
    task automatic t_contention;
        slot("R2_R5", 4'b0111, 8'b00_01_01_01, 4'b0000, 4'b0001, 4'b0110, 8'b00_10_00_01);
        slot("R3", 4'b0111, 8'b00_01_01_01, 4'b0000, 4'b0010, 4'b0101, 8'b00_10_01_00);
    endtask

    // R8: accept the shown open grants, then observe moved open pointers
    task automatic t_open_pointer;
        slot("R3_R7", 4'b0111, 8'b00_01_01_01, 4'b0101, 4'b0100, 4'b0011, 8'b00_01_10_00);
        slot("R8", 4'b1111, 8'b01_01_01_01, 4'b0000, 4'b1000, 4'b0111, 8'b01_11_00_10);
        slot("R8_hold", 4'b1111, 8'b01_01_01_01, 4'b0000, 4'b0001, 4'b1110, 8'b10_11_00_01);
    endtask

    // R4: link 1 untouched while only link 2 is requested
    task automatic t_idle_pointer;
        slot("R4_a", 4'b1010, 8'b10_00_10_00, 4'b0000, 4'b0010, 4'b1000, 8'b00_00_10_00);
        slot("R4_b", 4'b0011, 8'b00_00_01_01, 4'b0000, 4'b0010, 4'b0001, 8'b00_00_01_00);
    endtask

    // R9 R10: no requests, then fully distinct targets
    task automatic t_quiet_and_distinct;
        slot("R9_R10", 4'b0000, 8'b11_11_11_11, 4'b1111, 4'b0000, 4'b0000, 8'h00);
        slot("R2_distinct", 4'b1111, 8'b00_01_10_11, 4'b0000, 4'b1111, 4'b0000, 8'b00_01_10_11);
        slot("R9_one_slot", 4'b0000, 8'h00, 4'b0000, 4'b0000, 4'b0000, 8'h00);
    endtask

    initial begin
        t_reset();
        t_contention();
        t_open_pointer();
        t_idle_pointer();
        t_quiet_and_distinct();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule